// File: doc/BRIEF.md
# Receive Block-Ring FIFO Drain Controller

This block sits between a serial framing engine that produces received bytes and a DMA master that moves them to memory. Storage is a ring of `cfg_nblocks` equal blocks of `cfg_blk_bytes` bytes each. Every stored byte carries a sideband end-of-frame bit, so the reader can see where frames end.

Instead of asking for service on every byte, the block counts how many whole blocks the writer has completed since the last drain. It raises `dma_req` when that count reaches the programmed high watermark, or at once when the writer stores a byte flagged as end of frame. After that, the request stays up until the reader has taken every stored byte, whatever frame boundaries it passes on the way. Only then does the block count from zero again.

Configuration is static. It may change only while reset is held. The ring must have at least two blocks and no more than `MAX_BLOCKS`, and each block must hold at least one byte and no more than `MAX_BLK_BYTES`.

Top module: `rx_block_fifo_drain`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block empties and clears its state. After that edge, `dma_req` and `overflow` are 0.
- R2: A byte that is written while fewer than `cfg_nblocks*cfg_blk_bytes` bytes are stored is kept. The reader receives the bytes in write order on `rd_data`, with the written end-of-frame flag on `rd_eof`. Both are valid whenever `dma_req` is 1, and each `dma_ack` taken while `dma_req` is 1 moves to the next byte.
- R3: With no end-of-frame involved, `dma_req` becomes 1 in the cycle after the accepted write that completes the W-th whole block since the last drain ended. W is the effective watermark.
- R4: An accepted write with `wr_eof`=1, made while no drain is in progress, makes `dma_req` 1 in the next cycle, whatever the block count.
- R5: Once a drain has started, `dma_req` stays 1 until the stored byte count reaches zero, even across bytes flagged end-of-frame. It is 0 in the cycle after the last byte is popped, provided no write was accepted in that cycle.
- R6: When a drain ends, the completed-block count restarts at zero. Blocks completed while the drain was running are not counted. A block completion is the accepted write that fills the last byte of a block.
- R7: A watermark of 0, or of `cfg_nblocks` or more, drives `cfg_err` to 1 and is used as `cfg_nblocks`-1. Values from 1 to `cfg_nblocks`-1 drive `cfg_err` to 0 and are used as written.
- R8: A write made while `cfg_nblocks*cfg_blk_bytes` bytes are stored is dropped. The stored contents do not change, and `overflow` becomes 1 in the next cycle and stays 1 until reset.
- R9: `dma_ack` has no effect while `dma_req` is 0. No byte is removed.
- R10: Storage wraps after `cfg_nblocks*cfg_blk_bytes` bytes, so bytes written across the wrap point are read back in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_nblocks | input | BLK_W | Number of blocks in the ring (2..MAX_BLOCKS) |
| cfg_blk_bytes | input | BYT_W | Bytes per block (1..MAX_BLK_BYTES) |
| cfg_hiwm | input | BLK_W | High watermark in whole blocks |
| wr_en | input | 1 | Writer offers a byte |
| wr_data | input | DATA_W | Byte offered by the writer |
| wr_eof | input | 1 | Offered byte ends a frame |
| dma_req | output | 1 | Drain request; head byte valid |
| dma_ack | input | 1 | Reader takes the head byte |
| rd_data | output | DATA_W | Head byte |
| rd_eof | output | 1 | Head byte ends a frame |
| overflow | output | 1 | Sticky: a write was dropped |
| cfg_err | output | 1 | Watermark setting is out of range |

## Verification
Every result of this block appears in the cycle after the edge that causes it:
- a triggering write shows as `dma_req` after one edge;
- a pop moves `rd_data` to the next byte after one edge;
- a dropped write sets `overflow` after one edge.

`cfg_err` is purely combinational from the configuration inputs.

The bench drives inputs at the falling edge and compares outputs a moment later against a model state. It advances that model with exactly the inputs that the next rising edge will see. Each comparison therefore checks the effect of the previous cycle's stimulus, with no dependence on process order at the edge.

// File: rtl/rx_drain_pkg.sv
package rx_drain_pkg;
    // Drain controller states.
    typedef enum logic {
        ST_FILL  = 1'b0,
        ST_DRAIN = 1'b1
    } drain_state_e;
endpackage

// File: rtl/rx_wm_legalize.sv
// Watermark legalizer.
// Maps the programmed high watermark into the legal range 1..nblocks-1.
// Any out-of-range value is replaced by nblocks-1 and flagged.
// Assumes nblocks >= 2.
module rx_wm_legalize #(
    parameter int BLK_W = 4
) (
    input  logic [BLK_W-1:0] nblocks,
    input  logic [BLK_W-1:0] wm_in,
    output logic [BLK_W-1:0] wm_eff,
    output logic             wm_bad
);
    // Range check and substitution.
    always_comb begin
        wm_bad = (wm_in == '0) || (wm_in >= nblocks);
        wm_eff = wm_bad ? (nblocks - 1'b1) : wm_in;
    end
endmodule

// File: rtl/rx_ring_store.sv
// Ring storage of bytes with an end-of-frame sideband bit.
// The active capacity is `cap` bytes (blocks times block size). Pointers wrap
// at that capacity.
// The writer's offset inside its current block is tracked, so that a pulse
// marks every block completion.
// Writes while full are dropped and set a sticky flag.
// Assumes cap and blk_bytes are constant outside reset.
module rx_ring_store #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 128,
    parameter int PTR_W  = 7,
    parameter int LVL_W  = 8,
    parameter int BYT_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_eof,
    input  logic              rd_pop,
    input  logic [LVL_W-1:0]  cap,
    input  logic [BYT_W-1:0]  blk_bytes,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_eof,
    output logic [LVL_W-1:0]  level,
    output logic              wr_accept,
    output logic              blk_done,
    output logic              overflow
);
    logic [DATA_W:0]  mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [BYT_W-1:0] blk_off;
    logic             wr_wrap, rd_wrap;

    // Acceptance, block completion and wrap points.
    always_comb begin
        wr_accept = wr_en && (level < cap);
        blk_done  = wr_accept && (blk_off == blk_bytes - 1'b1);
        wr_wrap   = (LVL_W'(wr_ptr) == cap - 1'b1);
        rd_wrap   = (LVL_W'(rd_ptr) == cap - 1'b1);
        rd_data   = mem[rd_ptr][DATA_W-1:0];
        rd_eof    = mem[rd_ptr][DATA_W];
    end

    // Byte array write; no reset needed on data.
    always_ff @(posedge clk) begin
        if (wr_accept) mem[wr_ptr] <= {wr_eof, wr_data};
    end

    // Pointers, fill level, block offset and overflow flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            level    <= '0;
            blk_off  <= '0;
            overflow <= 1'b0;
        end else begin
            if (wr_accept) begin
                wr_ptr  <= wr_wrap ? '0 : wr_ptr + 1'b1;
                blk_off <= blk_done ? '0 : blk_off + 1'b1;
            end
            if (rd_pop) rd_ptr <= rd_wrap ? '0 : rd_ptr + 1'b1;
            case ({wr_accept, rd_pop})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
            if (wr_en && !wr_accept) overflow <= 1'b1;
        end
    end

    a_r8_level_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        level <= cap);
    a_r8_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);
    a_r2_level_still: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_accept && !rd_pop) |=> $stable(level));
endmodule

// File: rtl/rx_drain_fsm.sv
// Drain request state machine.
// In FILL state it counts block completions. It enters DRAIN when the count
// reaches the effective watermark, or when an end-of-frame byte is accepted.
// It leaves DRAIN only when the storage is empty and no write arrives in the
// same cycle. Leaving DRAIN clears the count.
// Assumes wm_eff >= 1.
module rx_drain_fsm
    import rx_drain_pkg::*;
#(
    parameter int BLK_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_accept,
    input  logic             wr_eof,
    input  logic             blk_done,
    input  logic [BLK_W-1:0] wm_eff,
    input  logic             fifo_empty,
    output logic             draining
);
    drain_state_e     state;
    logic [BLK_W-1:0] blk_cnt;
    logic [BLK_W-1:0] cnt_next;

    // Count value if the current write completes a block.
    always_comb cnt_next = blk_cnt + 1'b1;

    // State and completed-block counter update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_FILL;
            blk_cnt <= '0;
        end else if (state == ST_FILL) begin
            if ((wr_accept && wr_eof) || (blk_done && cnt_next >= wm_eff)) begin
                state   <= ST_DRAIN;
                blk_cnt <= '0;
            end else if (blk_done) begin
                blk_cnt <= cnt_next;
            end
        end else if (fifo_empty && !wr_accept) begin
            state   <= ST_FILL;
            blk_cnt <= '0;
        end
    end

    always_comb draining = (state == ST_DRAIN);

    a_r4_eof_starts_drain: assert property (@(posedge clk) disable iff (!rst_n)
        (!draining && wr_accept && wr_eof) |=> draining);
    a_r5_drain_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (draining && !fifo_empty) |=> draining);
    a_r6_count_below_wm: assert property (@(posedge clk) disable iff (!rst_n)
        !draining |-> (blk_cnt < wm_eff));
    a_r6_no_count_in_drain: assert property (@(posedge clk) disable iff (!rst_n)
        draining |-> (blk_cnt == '0));
endmodule

// File: rtl/rx_block_fifo_drain.sv
// Top level: receive block-ring FIFO with a high-watermark drain request.
// It joins the watermark legalizer, the ring storage and the drain state
// machine.
// A pop happens only on dma_ack while dma_req is high.
// Assumes the configuration is held constant outside reset.
module rx_block_fifo_drain #(
    parameter int DATA_W        = 8,
    parameter int MAX_BLOCKS    = 8,
    parameter int MAX_BLK_BYTES = 16,
    localparam int DEPTH = MAX_BLOCKS * MAX_BLK_BYTES,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int LVL_W = $clog2(DEPTH + 1),
    localparam int BLK_W = $clog2(MAX_BLOCKS + 1),
    localparam int BYT_W = $clog2(MAX_BLK_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BLK_W-1:0]  cfg_nblocks,
    input  logic [BYT_W-1:0]  cfg_blk_bytes,
    input  logic [BLK_W-1:0]  cfg_hiwm,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_eof,
    output logic              dma_req,
    input  logic              dma_ack,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_eof,
    output logic              overflow,
    output logic              cfg_err
);
    logic [BLK_W-1:0] wm_eff;
    logic [LVL_W-1:0] cap, level;
    logic             wr_accept, blk_done, draining, rd_pop;

    // Active capacity and the gated pop.
    always_comb begin
        cap     = LVL_W'(cfg_nblocks) * LVL_W'(cfg_blk_bytes);
        dma_req = draining && (level != '0);
        rd_pop  = dma_ack && dma_req;
    end

    rx_wm_legalize #(.BLK_W(BLK_W)) u_wm (
        .nblocks (cfg_nblocks),
        .wm_in   (cfg_hiwm),
        .wm_eff  (wm_eff),
        .wm_bad  (cfg_err)
    );

    rx_ring_store #(
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH),
        .PTR_W  (PTR_W),
        .LVL_W  (LVL_W),
        .BYT_W  (BYT_W)
    ) u_ring (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .wr_eof    (wr_eof),
        .rd_pop    (rd_pop),
        .cap       (cap),
        .blk_bytes (cfg_blk_bytes),
        .rd_data   (rd_data),
        .rd_eof    (rd_eof),
        .level     (level),
        .wr_accept (wr_accept),
        .blk_done  (blk_done),
        .overflow  (overflow)
    );

    rx_drain_fsm #(.BLK_W(BLK_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_accept  (wr_accept),
        .wr_eof     (wr_eof),
        .blk_done   (blk_done),
        .wm_eff     (wm_eff),
        .fifo_empty (level == '0),
        .draining   (draining)
    );

    a_r7_wm_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (wm_eff != '0) && (wm_eff < cfg_nblocks));
    a_r9_no_pop_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!dma_req && !wr_accept) |=> $stable(level));
    a_r5_req_until_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req && !rd_pop) |=> dma_req);
endmodule

// File: tb/rx_block_fifo_drain_bench.sv
module rx_block_fifo_drain_bench;
    localparam int DATA_W = 8;
    localparam int MAXB   = 8;
    localparam int MAXBB  = 16;
    localparam int BLK_W  = $clog2(MAXB + 1);
    localparam int BYT_W  = $clog2(MAXBB + 1);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [BLK_W-1:0]  cfg_nblocks = 4;
    logic [BYT_W-1:0]  cfg_blk_bytes = 4;
    logic [BLK_W-1:0]  cfg_hiwm = 3;
    logic              wr_en = 1'b0, wr_eof = 1'b0, dma_ack = 1'b0;
    logic [DATA_W-1:0] wr_data = '0;
    logic              dma_req, rd_eof, overflow, cfg_err;
    logic [DATA_W-1:0] rd_data;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // Bench model state
    logic [DATA_W:0] q[$];
    bit  m_drain, m_ovf;
    int  m_cnt, m_off, m_cap, m_wm, m_nb, m_bb;
    bit  m_bad;

    rx_block_fifo_drain #(.DATA_W(DATA_W), .MAX_BLOCKS(MAXB), .MAX_BLK_BYTES(MAXBB)) u_rx_block_fifo_drain (
        .clk(clk), .rst_n(rst_n), .cfg_nblocks(cfg_nblocks), .cfg_blk_bytes(cfg_blk_bytes),
        .cfg_hiwm(cfg_hiwm), .wr_en(wr_en), .wr_data(wr_data), .wr_eof(wr_eof),
        .dma_req(dma_req), .dma_ack(dma_ack), .rd_data(rd_data), .rd_eof(rd_eof),
        .overflow(overflow), .cfg_err(cfg_err));

    always #5 clk = ~clk;

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            checks++; errors++;
            $display("FAIL watchdog: run exceeded %0d cycles (expected completion)", cycles);
            finish_run();
        end
    end

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic bit legal_wm(int wm, int nb);
        return (wm >= 1) && (wm < nb);
    endfunction

    task automatic configure_and_reset(int nb, int bb, int wm);
        @(negedge clk);
        rst_n = 1'b0; wr_en = 0; dma_ack = 0; wr_eof = 0;
        cfg_nblocks = BLK_W'(nb); cfg_blk_bytes = BYT_W'(bb); cfg_hiwm = BLK_W'(wm);
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        q.delete(); m_drain = 0; m_ovf = 0; m_cnt = 0; m_off = 0;
        m_nb = nb; m_bb = bb; m_cap = nb * bb;
        m_bad = !legal_wm(wm, nb);
        m_wm = m_bad ? nb - 1 : wm;
        #1;
        chk("R1 dma_req after reset", int'(dma_req), 0);
        chk("R1 overflow after reset", int'(overflow), 0);
        chk("R7 cfg_err", int'(cfg_err), int'(m_bad));
    endtask

    // One cycle: drive at falling edge, compare, then advance the model.
    task automatic step(string tag, bit w, bit eof, bit ack);
        bit exp_req, pop, acc, bdone;
        @(negedge clk);
        wr_en = w; wr_eof = eof; dma_ack = ack; wr_data = DATA_W'($urandom);
        #1;
        exp_req = m_drain && (q.size() != 0);
        chk({tag, " R3 R4 R5 dma_req"}, int'(dma_req), int'(exp_req));
        chk({tag, " R8 overflow"}, int'(overflow), int'(m_ovf));
        chk({tag, " R7 cfg_err"}, int'(cfg_err), int'(m_bad));
        if (exp_req && dma_req)
            chk({tag, " R2 R10 head byte"}, int'({rd_eof, rd_data}), int'(q[0]));
        pop = ack && exp_req;
        acc = w && (q.size() < m_cap);
        bdone = acc && (m_off == m_bb - 1);
        if (!m_drain) begin
            if ((acc && eof) || (bdone && m_cnt + 1 >= m_wm)) begin
                m_drain = 1; m_cnt = 0;
            end else if (bdone) m_cnt++;
        end else if (q.size() == 0 && !acc) begin
            m_drain = 0; m_cnt = 0;
        end
        if (w && !acc) m_ovf = 1;
        if (pop) void'(q.pop_front());
        if (acc) begin
            q.push_back({eof, wr_data});
            m_off = bdone ? 0 : m_off + 1;
        end
    endtask

    task automatic drain_all(string tag);
        for (int i = 0; i < 300 && (q.size() != 0 || m_drain); i++) step(tag, 0, 0, 1);
    endtask

    task automatic random_phase(string tag, int n, int pw, int pe, int pa);
        for (int i = 0; i < n; i++)
            step(tag, ($urandom % 100) < pw, ($urandom % 100) < pe, ($urandom % 100) < pa);
        drain_all(tag);
    endtask

    initial begin
        void'($urandom(32'd12345));
        // Config A: 4 blocks of 4 bytes, watermark 3
        configure_and_reset(4, 4, 3);
        for (int i = 0; i < 11; i++) step("R3 below watermark", 1, 0, 1);
        step("R9 ack while idle", 0, 0, 1);
        chk("R9 no request before third block", int'(dma_req), 0);
        step("R3 third block", 1, 0, 0);
        step("R3 request due", 0, 0, 0);
        chk("R3 request after third block", int'(dma_req), 1);
        // A second frame is added while draining; drain must cross both ends.
        step("R5 eof in drain", 1, 1, 0);
        for (int i = 0; i < 3; i++) step("R5 second frame", 1, 0, 1);
        step("R5 eof in drain", 1, 1, 1);
        drain_all("R5 full drain");
        chk("R5 request low when empty", int'(dma_req), 0);
        // Restart of the count: two blocks must not trigger.
        for (int i = 0; i < 8; i++) step("R6 count restart", 1, 0, 0);
        step("R6 count restart", 0, 0, 0);
        chk("R6 no request after two blocks", int'(dma_req), 0);
        step("R4 eof trigger", 1, 1, 0);
        step("R4 eof trigger", 0, 0, 0);
        chk("R4 request after eof", int'(dma_req), 1);
        // Fill past capacity without draining.
        for (int i = 0; i < 10; i++) step("R8 overflow", 1, 0, 0);
        chk("R8 overflow sticky", int'(overflow), 1);
        drain_all("R8 R10 drain after overflow");
        chk("R8 overflow stays", int'(overflow), 1);
        random_phase("R2 R10 random A", 3000, 50, 3, 60);

        // Config B: 8 blocks of 16 bytes, watermark 1
        configure_and_reset(8, 16, 1);
        random_phase("R3 random B", 3000, 60, 1, 40);

        // Config C: illegal watermark 0 on 5 blocks of 3 bytes
        configure_and_reset(5, 3, 0);
        chk("R7 zero watermark flagged", int'(cfg_err), 1);
        for (int i = 0; i < 12; i++) step("R7 effective wm four", 1, 0, 0);
        step("R7 effective wm four", 0, 0, 0);
        chk("R7 request after four blocks", int'(dma_req), 1);
        drain_all("R7 drain");
        random_phase("R7 random C", 3000, 40, 5, 50);

        // Config D: illegal watermark 9 on 8 blocks of 2 bytes
        configure_and_reset(8, 2, 9);
        chk("R7 high watermark flagged", int'(cfg_err), 1);
        random_phase("R10 random D", 3000, 70, 2, 30);

        // Config E: smallest ring, 2 blocks of 1 byte, watermark 1
        configure_and_reset(2, 1, 1);
        random_phase("R8 random E", 2000, 80, 10, 20);
        finish_run();
    end
endmodule